// File: doc/BRIEF.md
# Dual-Master Bus Channel Selector

This block decides which of two upstream bus masters is wired through to a shared downstream bus. Each master issues "take the bus" strobes through its own simple command port. The block drives a pair of one-hot channel enables that close the matching pass switch. Either master may seize the bus at any moment, for example when its peer has failed or been removed. The master that loses the bus is told through its own interrupt line.

Each master has one active-low interrupt output. Three sticky causes feed it. The downstream interrupt line is fanned out to both ports. A loss-of-control notice goes to the displaced owner. A recovery-done notice goes to the new owner. Each cause has a mask bit per port, and each port has a clear strobe for its own causes. A build parameter fixes the state after reset: either channel 0 is connected, or no channel is connected. A second parameter puts an external recovery sequencer in the switch path. When it is set, the new channel stays open until the sequencer reports completion.

Top module: `dual_master_sel`

## Requirements
- R1: At most one bit of `ch_en` is ever high; bit 0 connects master 0 and bit 1 connects master 1.
- R2: After reset `ch_en` is 2'b01 when `RESET_CH0`=1 and 2'b00 when `RESET_CH0`=0. All status and mask bits are zero, so `int_up_n` is 2'b11 and `rec_req` is 0.
- R3: With `USE_RECOVERY`=0, a `take_req` bit from a master that is not connected makes `ch_en` select that master one clock later.
- R4: When both `take_req` bits are high in the same cycle, channel 0 wins and the master 1 request has no effect.
- R5: When the bus passes from one master to the other, the loss-of-control status (bit 1) of the previous owner's port is set one clock later. While unmasked, it pulls that port's `int_up_n` bit low.
- R6: A `take_req` from the master that is already connected changes nothing and raises no interrupt.
- R7: While `int_dn_n` is low at a clock edge, the downstream status (bit 0) of both ports is set. Each port's `int_up_n` bit is the active-low OR of its status bits whose mask bit is 0.
- R8: A mask bit of 1 (written through `mask_wr[p]` with `mask_valP`) keeps that cause from asserting the port's output. The status stays sticky, so clearing the mask later reveals it.
- R9: A `clr_stb[p]` pulse clears the status bits of port p that `clr_selP` selects, and no bits of the other port. A cause that is set in the same cycle wins over the clear.
- R10: With `USE_RECOVERY`=1, a switch drives `ch_en` to 2'b00 and raises `rec_req` one clock later. The new owner's enable appears one clock after a `rec_done` pulse. At that same edge `rec_req` falls and the new owner's recovery-done status (bit 2) is set.
- R11: Requests that arrive while a recovery is pending are dropped. A `rec_done` pulse while nothing is pending has no effect.
- R12: Pulling `rst_n` low restores the R2 state at once, without waiting for a clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| int_dn_n | input | 1 | Active-low downstream interrupt |
| take_req | input | 2 | Take-bus strobe, bit p from master p |
| mask_wr | input | 2 | Mask write strobe, bit p for port p |
| mask_val0 | input | 3 | New mask for port 0 (1 = masked) |
| mask_val1 | input | 3 | New mask for port 1 (1 = masked) |
| clr_stb | input | 2 | Status clear strobe, bit p for port p |
| clr_sel0 | input | 3 | Status bits of port 0 to clear |
| clr_sel1 | input | 3 | Status bits of port 1 to clear |
| rec_done | input | 1 | Recovery sequencer completion pulse |
| ch_en | output | 2 | One-hot channel enables to the pass switches |
| int_up_n | output | 2 | Active-low interrupt to master p |
| rec_req | output | 1 | Recovery pending, sequencer should run |

## Verification
A wrong selection register shows up on `ch_en` in the very next cycle, and a double enable breaks the one-hot rule at once. A status or mask bit in the wrong state stays invisible until that cause is unmasked. The bench therefore pairs mask writes with downstream pulses and clears, so a stuck or lost sticky bit reaches `int_up_n` within one or two cycles. A recovery state machine that jumps early or never leaves its wait state shows as an enable during `rec_req`, or as `rec_req` that outlives a `rec_done` pulse.

// File: rtl/dms_pkg.sv
package dms_pkg;
   localparam int DMS_NCH   = 2;
   localparam int DMS_NSRC  = 3;
   // status / mask bit positions inside every port
   localparam int SRC_DN    = 0;
   localparam int SRC_LOST  = 1;
   localparam int SRC_RDONE = 2;

   typedef logic [DMS_NSRC-1:0] dms_src_t;
   typedef logic [DMS_NCH-1:0]  dms_ch_t;

   typedef enum logic {
      ARB_IDLE = 1'b0,
      ARB_WAIT = 1'b1
   } arb_state_t;
endpackage

// File: rtl/dms_arbiter.sv
module dms_arbiter
   import dms_pkg::*;
#(
   parameter int RESET_CH0    = 1,
   parameter int USE_RECOVERY = 0
) (
   input  logic    clk,
   input  logic    rst_n,
   input  dms_ch_t take_req,
   input  logic    rec_done,
   output dms_ch_t ch_en,
   output logic    rec_req,
   output dms_ch_t lost_evt,
   output dms_ch_t done_evt
);
   localparam dms_ch_t RST_SEL = (RESET_CH0 != 0) ? dms_ch_t'(1) : dms_ch_t'(0);

   dms_ch_t sel_q;
   dms_ch_t grant_oh;
   logic    busy;
   logic    do_switch;

   // channel 0 has priority over channel 1
   always_comb begin
      grant_oh = '0;
      if (take_req[0])      grant_oh[0] = 1'b1;
      else if (take_req[1]) grant_oh[1] = 1'b1;
   end

   assign do_switch = (|grant_oh) && !busy && (grant_oh != sel_q);
   assign lost_evt  = do_switch ? sel_q : '0;
   assign ch_en     = sel_q;

   generate
      if (USE_RECOVERY != 0) begin : g_recov
         arb_state_t st_q;
         dms_ch_t    tgt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               st_q  <= ARB_IDLE;
               tgt_q <= '0;
               sel_q <= RST_SEL;
            end else begin
               unique case (st_q)
                  ARB_IDLE: begin
                     if (do_switch) begin
                        st_q  <= ARB_WAIT;
                        tgt_q <= grant_oh;
                        sel_q <= '0;
                     end
                  end
                  ARB_WAIT: begin
                     if (rec_done) begin
                        st_q  <= ARB_IDLE;
                        sel_q <= tgt_q;
                     end
                  end
                  default: st_q <= ARB_IDLE;
               endcase
            end
         end

         assign busy     = (st_q == ARB_WAIT);
         assign rec_req  = busy;
         assign done_evt = (busy && rec_done) ? tgt_q : '0;
      end else begin : g_direct
         logic unused_rec;
         assign unused_rec = rec_done;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         sel_q <= RST_SEL;
            else if (do_switch) sel_q <= grant_oh;
         end

         assign busy     = 1'b0;
         assign rec_req  = 1'b0;
         assign done_evt = '0;
      end
   endgenerate
endmodule

// File: rtl/dms_irq_port.sv
module dms_irq_port #(
   parameter int NSRC = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] set_evt,
   input  logic            clr_stb,
   input  logic [NSRC-1:0] clr_sel,
   input  logic            mask_wr,
   input  logic [NSRC-1:0] mask_val,
   output logic            int_n,
   output logic [NSRC-1:0] mask_q
);
   generate
      if (NSRC < 1) begin : g_bad_nsrc
         $error("dms_irq_port: NSRC must be at least 1");
      end
   endgenerate

   logic [NSRC-1:0] stat_q;
   logic [NSRC-1:0] clr_vec;

   assign clr_vec = clr_stb ? clr_sel : '0;

   // set wins over clear so no event is lost
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_q <= '0;
         mask_q <= '0;
      end else begin
         stat_q <= (stat_q & ~clr_vec) | set_evt;
         if (mask_wr) mask_q <= mask_val;
      end
   end

   assign int_n = ~|(stat_q & ~mask_q);
endmodule

// File: rtl/dual_master_sel.sv
module dual_master_sel
   import dms_pkg::*;
#(
   parameter int RESET_CH0    = 1,
   parameter int USE_RECOVERY = 0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                int_dn_n,
   input  logic [1:0]          take_req,
   input  logic [1:0]          mask_wr,
   input  logic [DMS_NSRC-1:0] mask_val0,
   input  logic [DMS_NSRC-1:0] mask_val1,
   input  logic [1:0]          clr_stb,
   input  logic [DMS_NSRC-1:0] clr_sel0,
   input  logic [DMS_NSRC-1:0] clr_sel1,
   input  logic                rec_done,
   output logic [1:0]          ch_en,
   output logic [1:0]          int_up_n,
   output logic                rec_req
);
   generate
      if (!(RESET_CH0 inside {0, 1})) begin : g_bad_rst
         $error("dual_master_sel: RESET_CH0 must be 0 or 1");
      end
      if (!(USE_RECOVERY inside {0, 1})) begin : g_bad_rec
         $error("dual_master_sel: USE_RECOVERY must be 0 or 1");
      end
      if (DMS_NSRC <= SRC_RDONE || DMS_NCH != 2) begin : g_bad_pkg
         $error("dual_master_sel: package sizes do not fit the cause map");
      end
   endgenerate

   dms_ch_t  lost_evt;
   dms_ch_t  done_evt;
   logic     dn_evt;
   dms_src_t mask_val_a [DMS_NCH];
   dms_src_t clr_sel_a  [DMS_NCH];
   dms_src_t mask_q_a   [DMS_NCH];
   dms_src_t mask0_q;
   dms_src_t mask1_q;

   assign dn_evt        = ~int_dn_n;
   assign mask_val_a[0] = mask_val0;
   assign mask_val_a[1] = mask_val1;
   assign clr_sel_a[0]  = clr_sel0;
   assign clr_sel_a[1]  = clr_sel1;
   assign mask0_q       = mask_q_a[0];
   assign mask1_q       = mask_q_a[1];

   dms_arbiter #(
      .RESET_CH0    (RESET_CH0),
      .USE_RECOVERY (USE_RECOVERY)
   ) u_arb (
      .clk      (clk),
      .rst_n    (rst_n),
      .take_req (take_req),
      .rec_done (rec_done),
      .ch_en    (ch_en),
      .rec_req  (rec_req),
      .lost_evt (lost_evt),
      .done_evt (done_evt)
   );

   generate
      for (genvar p = 0; p < DMS_NCH; p++) begin : g_port
         dms_src_t set_vec;

         always_comb begin
            set_vec            = '0;
            set_vec[SRC_DN]    = dn_evt;
            set_vec[SRC_LOST]  = lost_evt[p];
            set_vec[SRC_RDONE] = done_evt[p];
         end

         dms_irq_port #(
            .NSRC (DMS_NSRC)
         ) u_port (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_evt  (set_vec),
            .clr_stb  (clr_stb[p]),
            .clr_sel  (clr_sel_a[p]),
            .mask_wr  (mask_wr[p]),
            .mask_val (mask_val_a[p]),
            .int_n    (int_up_n[p]),
            .mask_q   (mask_q_a[p])
         );
      end
   endgenerate
endmodule

// File: rtl/dms_checker.sv
module dms_checker #(
   parameter int USE_RECOVERY = 0
) (
   input logic       clk,
   input logic       rst_n,
   input logic [1:0] take_req,
   input logic       rec_done,
   input logic       rec_req,
   input logic [1:0] ch_en,
   input logic [1:0] int_up_n,
   input logic [1:0] mask_wr,
   input logic [2:0] mask0_q,
   input logic [2:0] mask1_q
);
   // R1
   a_r1_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ch_en));

   // R3
   a_r3_take_ch1: assert property (@(posedge clk) disable iff (!rst_n)
      (USE_RECOVERY == 0 && take_req == 2'b10) |=> (ch_en == 2'b10));

   // R4
   a_r4_tie_ch0: assert property (@(posedge clk) disable iff (!rst_n)
      (USE_RECOVERY == 0 && take_req == 2'b11) |=> (ch_en == 2'b01));

   // R5
   a_r5_lost_port0: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_en == 2'b01 && take_req == 2'b10 && !mask_wr[0] && !mask0_q[1])
      |=> !int_up_n[0]);

   a_r5_lost_port1: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_en == 2'b10 && take_req[0] && !mask_wr[1] && !mask1_q[1])
      |=> !int_up_n[1]);

   // R6
   a_r6_owner_repeat: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_en == 2'b01 && take_req[0] && !rec_req) |=> (ch_en == 2'b01));

   // R8
   a_r8_all_masked0: assert property (@(posedge clk) disable iff (!rst_n)
      (mask0_q == 3'b111) |-> int_up_n[0]);

   a_r8_all_masked1: assert property (@(posedge clk) disable iff (!rst_n)
      (mask1_q == 3'b111) |-> int_up_n[1]);

   // R10
   a_r10_hold_open: assert property (@(posedge clk) disable iff (!rst_n)
      (rec_req && !rec_done) |=> (ch_en == 2'b00 && rec_req));

   a_r10_finish: assert property (@(posedge clk) disable iff (!rst_n)
      (rec_req && rec_done) |=> (ch_en != 2'b00 && !rec_req));

   a_r10_off_during_wait: assert property (@(posedge clk) disable iff (!rst_n)
      rec_req |-> (ch_en == 2'b00));

   // R11
   a_r11_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!rec_req && take_req == 2'b00) |=> $stable(ch_en));
endmodule

bind dual_master_sel dms_checker #(
   .USE_RECOVERY (USE_RECOVERY)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .take_req (take_req),
   .rec_done (rec_done),
   .rec_req  (rec_req),
   .ch_en    (ch_en),
   .int_up_n (int_up_n),
   .mask_wr  (mask_wr),
   .mask0_q  (mask0_q),
   .mask1_q  (mask1_q)
);

// File: tb/dual_master_sel_tb_top.sv
module dual_master_sel_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       int_dn_n = 1'b1;
   logic [1:0] take_req = '0;
   logic [1:0] mask_wr = '0;
   logic [2:0] mask_val0 = '0, mask_val1 = '0;
   logic [1:0] clr_stb = '0;
   logic [2:0] clr_sel0 = '0, clr_sel1 = '0;
   logic       rec_done = 1'b0;

   logic [1:0] ch_a, int_a, ch_b, int_b;
   logic       rq_a, rq_b;

   int total = 0;
   int bad   = 0;

   always #2 clk = ~clk;

   // variant A: channel 0 at reset, direct switching
   dual_master_sel #(.RESET_CH0(1), .USE_RECOVERY(0)) dut_i (
      .clk(clk), .rst_n(rst_n), .int_dn_n(int_dn_n), .take_req(take_req),
      .mask_wr(mask_wr), .mask_val0(mask_val0), .mask_val1(mask_val1),
      .clr_stb(clr_stb), .clr_sel0(clr_sel0), .clr_sel1(clr_sel1),
      .rec_done(rec_done), .ch_en(ch_a), .int_up_n(int_a), .rec_req(rq_a));

   // variant B: no channel at reset, recovery in the switch path
   dual_master_sel #(.RESET_CH0(0), .USE_RECOVERY(1)) dut_r (
      .clk(clk), .rst_n(rst_n), .int_dn_n(int_dn_n), .take_req(take_req),
      .mask_wr(mask_wr), .mask_val0(mask_val0), .mask_val1(mask_val1),
      .clr_stb(clr_stb), .clr_sel0(clr_sel0), .clr_sel1(clr_sel1),
      .rec_done(rec_done), .ch_en(ch_b), .int_up_n(int_b), .rec_req(rq_b));

   // reference state, index 0 = variant A, 1 = variant B
   logic [1:0] m_own [2];
   logic       m_pend [2];
   logic [1:0] m_tgt [2];
   logic [2:0] m_st [2][2];
   logic [2:0] m_mk [2][2];

   task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
      end
   endtask

   task automatic model_reset();
      m_own[0] = 2'b01;
      m_own[1] = 2'b00;
      for (int v = 0; v < 2; v++) begin
         m_pend[v] = 1'b0;
         m_tgt[v]  = 2'b00;
         for (int p = 0; p < 2; p++) begin
            m_st[v][p] = '0;
            m_mk[v][p] = '0;
         end
      end
   endtask

   task automatic model_step();
      for (int v = 0; v < 2; v++) begin
         logic [1:0] lost, done, nown, g;
         logic       npend;
         lost = '0; done = '0; nown = m_own[v]; npend = m_pend[v];
         if (!m_pend[v]) begin
            if (take_req != 2'b00) begin
               g = take_req[0] ? 2'b01 : 2'b10;
               if (g != m_own[v]) begin
                  lost = m_own[v];
                  if (v == 1) begin
                     nown = 2'b00; npend = 1'b1; m_tgt[v] = g;
                  end else begin
                     nown = g;
                  end
               end
            end
         end else if (rec_done) begin
            nown = m_tgt[v]; npend = 1'b0; done = m_tgt[v];
         end
         for (int p = 0; p < 2; p++) begin
            logic [2:0] setv, clrv;
            setv = {done[p], lost[p], ~int_dn_n};
            clrv = clr_stb[p] ? (p == 0 ? clr_sel0 : clr_sel1) : 3'b000;
            m_st[v][p] = (m_st[v][p] & ~clrv) | setv;
            if (mask_wr[p]) m_mk[v][p] = (p == 0) ? mask_val0 : mask_val1;
         end
         m_own[v]  = nown;
         m_pend[v] = npend;
      end
   endtask

   function automatic logic [1:0] exp_int(input int v);
      exp_int[0] = ~|(m_st[v][0] & ~m_mk[v][0]);
      exp_int[1] = ~|(m_st[v][1] & ~m_mk[v][1]);
   endfunction

   task automatic compare_all();
      chk("R1", {3'b000, $onehot0(ch_a)}, 4'h1);
      chk("R1", {3'b000, $onehot0(ch_b)}, 4'h1);
      chk("R3", ch_a, m_own[0]);
      chk("R3", ch_b, m_own[1]);
      chk("R7", int_a, exp_int(0));
      chk("R7", int_b, exp_int(1));
      chk("R10", rq_b, m_pend[1]);
   endtask

   task automatic idle();
      take_req = '0; mask_wr = '0; clr_stb = '0; rec_done = 1'b0; int_dn_n = 1'b1;
      mask_val0 = '0; mask_val1 = '0; clr_sel0 = '0; clr_sel1 = '0;
   endtask

   task automatic cyc();
      @(posedge clk);
      model_step();
      @(negedge clk);
      compare_all();
      idle();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [15:0] lf;
      model_reset();
      idle();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R2 reset state of both variants
      chk("R2", ch_a, 4'h1);  chk("R2", ch_b, 4'h0);
      chk("R2", int_a, 4'h3); chk("R2", int_b, 4'h3);
      chk("R2", {rq_b, rq_a}, 4'h0);

      take_req = 2'b10; cyc();
      chk("R3", ch_a, 4'h2);  chk("R5", int_a, 4'h2);
      chk("R10", ch_b, 4'h0); chk("R10", rq_b, 4'h1);

      take_req = 2'b01; cyc();
      chk("R5", int_a, 4'h0); chk("R11", ch_b, 4'h0);

      rec_done = 1'b1; cyc();
      chk("R11", ch_a, 4'h1); chk("R10", ch_b, 4'h2);
      chk("R10", int_b, 4'h1); chk("R10", rq_b, 4'h0);

      clr_stb = 2'b11; clr_sel0 = 3'b111; clr_sel1 = 3'b111; cyc();
      chk("R9", int_a, 4'h3); chk("R9", int_b, 4'h3);

      take_req = 2'b11; cyc();
      chk("R6", ch_a, 4'h1);  chk("R6", int_a, 4'h3);
      chk("R4", int_b, 4'h1); chk("R4", rq_b, 4'h1);

      rec_done = 1'b1; cyc();
      chk("R4", ch_b, 4'h1);  chk("R10", int_b, 4'h0);

      clr_stb = 2'b10; clr_sel0 = 3'b111; clr_sel1 = 3'b111; cyc();
      chk("R9", int_b, 4'h2); chk("R9", int_a, 4'h3);

      mask_wr = 2'b11; mask_val0 = 3'b001; mask_val1 = 3'b001; int_dn_n = 1'b0; cyc();
      chk("R8", int_a, 4'h3); chk("R8", int_b, 4'h2);

      mask_wr = 2'b11; cyc();
      chk("R8", int_a, 4'h0); chk("R7", int_b, 4'h0);

      int_dn_n = 1'b0; clr_stb = 2'b11; clr_sel0 = 3'b111; clr_sel1 = 3'b111; cyc();
      chk("R9", int_a, 4'h0);

      clr_stb = 2'b11; clr_sel0 = 3'b111; clr_sel1 = 3'b111; cyc();
      chk("R9", int_a, 4'h3); chk("R9", int_b, 4'h3);

      mask_wr = 2'b01; mask_val0 = 3'b111; take_req = 2'b10; cyc();
      chk("R5", ch_a, 4'h2); chk("R8", int_a, 4'h3);

      // R12 asynchronous reset
      #1 rst_n = 1'b0;
      #0.5;
      model_reset();
      chk("R12", ch_a, 4'h1);  chk("R12", ch_b, 4'h0);
      chk("R12", int_a, 4'h3); chk("R12", {rq_b, rq_a}, 4'h0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      compare_all();

      // sweep of mixed stimulus against the reference
      lf = 16'hACE1;
      for (int n = 0; n < 4000; n++) begin
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         take_req  = (lf[3:2] == 2'b00) ? lf[5:4] : 2'b00;
         rec_done  = lf[6] & lf[7];
         int_dn_n  = !(lf[8] & lf[9] & lf[10]);
         mask_wr   = (lf[11:9] == 3'b000) ? lf[13:12] : 2'b00;
         mask_val0 = lf[2:0];
         mask_val1 = lf[5:3];
         clr_stb   = lf[15:14] & {lf[1], lf[0]};
         clr_sel0  = lf[12:10];
         clr_sel1  = lf[9:7];
         cyc();
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule